// File: doc/BRIEF.md
# Multi-Mode Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. A shared, free-running 64-bit main counter is fed in from outside. The channel compares that count against its own comparator register and raises a one-cycle match pulse when they are equal. The match pulse is only raised while the channel interrupt enable and a global enable input are both high.

The channel works in one-shot or periodic mode. In periodic mode, every match advances the comparator by a stored period. A 32-bit mode restricts the comparison and the advance to the low half of the count.

Software reaches the channel's configuration, comparator and message registers as 32-bit words over a plain read/write port. Several writes have side effects, and these side effects carry most of the channel's behaviour:

- In periodic mode, a comparator low-word write is redirected to the period register.
- A one-shot set-value flag lets the comparator itself be loaded instead.
- Switching to 32-bit mode truncates the stored values.

Top module: `evt_cmp_channel`

## Requirements
- R1: After synchronous reset, both words of the comparator read 0xFFFFFFFF. Both message words read 0. The low configuration word reads 0x00000030 (bit 4 periodic-capable, bit 5 wide-capable). The high configuration word reads the ROUTE_CAP parameter.
- R2: A write to word 0 replaces the whole low configuration word, including the capability bits. A write to word 1 is ignored, because the high configuration word is read-only.
- R3: A configuration write that sets bit 8 (32-bit mode) clears the upper 32 bits of the comparator and of the period in the same cycle.
- R4: A write to word 2 loads the comparator low word when bit 3 (periodic) is clear or bit 6 (set-value) is set. Otherwise it loads the period low word and leaves the comparator unchanged. Word 3 follows the same rule for the high words.
- R5: Every accepted write to word 2 or word 3 clears configuration bit 6.
- R6: While bit 8 is set, writes to word 3 are ignored.
- R7: Word 4 is the low half of the message register and word 5 is the high half. A write to one half keeps the other half.
- R8: The read data is combinational from the address. Word 0/1 return the configuration halves, 2/3 the comparator halves, 4/5 the message halves, and 6/7 return zero.
- R9: A match occurs when the 64-bit count equals the comparator. With bit 8 set, only the low 32 bits of the count and the comparator are compared.
- R10: In periodic mode, each enabled match adds the period to the comparator. The sum wraps at 2^32 with bit 8 set, and at 2^64 otherwise.
- R11: match_o is high in the cycle after a clock edge at which a match occurred while bit 2 (interrupt enable) and glb_en_i were both high. Otherwise match_o is low.
- R12: irq_en_o reflects configuration bit 2, and level_type_o reflects bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 64 | Shared main counter value |
| glb_en_i | input | 1 | Global enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | 32-bit word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| match_o | output | 1 | One-cycle match pulse |
| irq_en_o | output | 1 | Channel interrupt enable bit |
| level_type_o | output | 1 | Trigger type bit |

## Verification
A wrong comparator or period value shows at the ports in two ways. It is visible on the very next read of word 2 or 3. It also moves match_o: a wrong period shifts every pulse after the first one in a periodic run, so one sweep exposes it within a single period. A side effect that is lost or misrouted can be told from a correct one by reading back the configuration and comparator words at once. This covers set-value not clearing, truncation not happening, or a low write landing in the wrong register. Sweeping the count densely across each match point, including the 32-bit wrap, catches off-by-one compares and width errors in the cycle where they happen.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;
    localparam int REG_W  = 64;
    localparam int HALF_W = REG_W / 2;
    localparam int ADDR_W = 3;

    localparam int B_LEVEL    = 1;
    localparam int B_IEN      = 2;
    localparam int B_PERIODIC = 3;
    localparam int B_PER_CAP  = 4;
    localparam int B_WIDE_CAP = 5;
    localparam int B_SETVAL   = 6;
    localparam int B_NARROW   = 8;

    typedef enum logic [ADDR_W-1:0] {
        W_CFG_LO = 3'd0,
        W_CFG_HI = 3'd1,
        W_CMP_LO = 3'd2,
        W_CMP_HI = 3'd3,
        W_MSG_LO = 3'd4,
        W_MSG_HI = 3'd5
    } word_e;

    typedef struct packed {
        logic cfg_lo;
        logic cmp_lo;
        logic cmp_hi;
        logic msg_lo;
        logic msg_hi;
    } wsel_t;

    typedef struct packed {
        logic level;
        logic ien;
        logic periodic;
        logic setval;
        logic narrow;
    } mode_t;

    function automatic logic [REG_W-1:0] cfg_reset(input logic [HALF_W-1:0] route);
        logic [HALF_W-1:0] lo;
        lo = '0;
        lo[B_PER_CAP]  = 1'b1;
        lo[B_WIDE_CAP] = 1'b1;
        return {route, lo};
    endfunction

    function automatic mode_t decode_mode(input logic [REG_W-1:0] cfg);
        mode_t m;
        m.level    = cfg[B_LEVEL];
        m.ien      = cfg[B_IEN];
        m.periodic = cfg[B_PERIODIC];
        m.setval   = cfg[B_SETVAL];
        m.narrow   = cfg[B_NARROW];
        return m;
    endfunction
endpackage

// File: rtl/evt_word_decode.sv
module evt_word_decode
    import evt_cmp_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output wsel_t             sel
);
    always_comb begin
        sel = '0;
        if (wr_en) begin
            unique case (addr)
                W_CFG_LO: sel.cfg_lo = 1'b1;
                W_CMP_LO: sel.cmp_lo = 1'b1;
                W_CMP_HI: sel.cmp_hi = 1'b1;
                W_MSG_LO: sel.msg_lo = 1'b1;
                W_MSG_HI: sel.msg_hi = 1'b1;
                default:  sel = '0;
            endcase
        end
    end
endmodule

// File: rtl/evt_match_unit.sv
module evt_match_unit
    import evt_cmp_pkg::*;
(
    input  logic [REG_W-1:0] cnt,
    input  logic [REG_W-1:0] cmp,
    input  logic [REG_W-1:0] period,
    input  logic             narrow,
    output logic             hit,
    output logic [REG_W-1:0] cmp_adv
);
    logic [REG_W-1:0] sum;

    always_comb begin
        sum = cmp + period;
        if (narrow) begin
            hit     = (cnt[HALF_W-1:0] == cmp[HALF_W-1:0]);
            cmp_adv = {{HALF_W{1'b0}}, sum[HALF_W-1:0]};
        end else begin
            hit     = (cnt == cmp);
            cmp_adv = sum;
        end
    end
endmodule

// File: rtl/evt_read_mux.sv
module evt_read_mux
    import evt_cmp_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  cfg,
    input  logic [REG_W-1:0]  cmp,
    input  logic [REG_W-1:0]  msg,
    output logic [HALF_W-1:0] rdata
);
    always_comb begin
        unique case (addr)
            W_CFG_LO: rdata = cfg[HALF_W-1:0];
            W_CFG_HI: rdata = cfg[REG_W-1:HALF_W];
            W_CMP_LO: rdata = cmp[HALF_W-1:0];
            W_CMP_HI: rdata = cmp[REG_W-1:HALF_W];
            W_MSG_LO: rdata = msg[HALF_W-1:0];
            W_MSG_HI: rdata = msg[REG_W-1:HALF_W];
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evt_cmp_pkg::*;
#(
    parameter logic [31:0] ROUTE_CAP = 32'h00F0_0C00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] cnt_i,
    input  logic        glb_en_i,
    input  logic        wr_en_i,
    input  logic [2:0]  addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        match_o,
    output logic        irq_en_o,
    output logic        level_type_o
);
    logic [REG_W-1:0] cfg_q, cfg_n;
    logic [REG_W-1:0] cmp_q, cmp_n;
    logic [REG_W-1:0] period_q, period_n;
    logic [REG_W-1:0] msg_q, msg_n;
    logic             match_q;

    wsel_t            sel;
    mode_t            mode;
    logic             hit;
    logic             fire;
    logic             to_cmp;
    logic [REG_W-1:0] cmp_adv;

    assign mode = decode_mode(cfg_q);

    evt_word_decode u_dec (
        .wr_en (wr_en_i),
        .addr  (addr_i),
        .sel   (sel)
    );

    evt_match_unit u_match (
        .cnt     (cnt_i),
        .cmp     (cmp_q),
        .period  (period_q),
        .narrow  (mode.narrow),
        .hit     (hit),
        .cmp_adv (cmp_adv)
    );

    evt_read_mux u_rd (
        .addr  (addr_i),
        .cfg   (cfg_q),
        .cmp   (cmp_q),
        .msg   (msg_q),
        .rdata (rdata_o)
    );

    assign fire   = hit && mode.ien && glb_en_i;
    assign to_cmp = !mode.periodic || mode.setval;

    always_comb begin
        cfg_n    = cfg_q;
        cmp_n    = cmp_q;
        period_n = period_q;
        msg_n    = msg_q;

        if (fire && mode.periodic) begin
            cmp_n = cmp_adv;
        end

        if (sel.cfg_lo) begin
            cfg_n[HALF_W-1:0] = wdata_i;
            if (wdata_i[B_NARROW]) begin
                cmp_n    = {{HALF_W{1'b0}}, cmp_q[HALF_W-1:0]};
                period_n = {{HALF_W{1'b0}}, period_q[HALF_W-1:0]};
            end
        end

        if (sel.cmp_lo) begin
            if (to_cmp) cmp_n[HALF_W-1:0]    = wdata_i;
            else        period_n[HALF_W-1:0] = wdata_i;
            cfg_n[B_SETVAL] = 1'b0;
        end

        if (sel.cmp_hi && !mode.narrow) begin
            if (to_cmp) cmp_n[REG_W-1:HALF_W]    = wdata_i;
            else        period_n[REG_W-1:HALF_W] = wdata_i;
            cfg_n[B_SETVAL] = 1'b0;
        end

        if (sel.msg_lo) msg_n[HALF_W-1:0]     = wdata_i;
        if (sel.msg_hi) msg_n[REG_W-1:HALF_W] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= cfg_reset(ROUTE_CAP);
            cmp_q    <= '1;
            period_q <= '1;
            msg_q    <= '0;
            match_q  <= 1'b0;
        end else begin
            cfg_q    <= cfg_n;
            cmp_q    <= cmp_n;
            period_q <= period_n;
            msg_q    <= msg_n;
            match_q  <= fire;
        end
    end

    assign match_o      = match_q;
    assign irq_en_o     = mode.ien;
    assign level_type_o = mode.level;
endmodule

// File: rtl/evt_cmp_channel_chk.sv
module evt_cmp_channel_chk #(
    parameter logic [31:0] ROUTE_CAP = 32'h00F0_0C00
) (
    input logic        clk,
    input logic        rst,
    input logic        glb_en_i,
    input logic        wr_en_i,
    input logic [2:0]  addr_i,
    input logic [31:0] wdata_i,
    input logic        match_o,
    input logic        irq_en_o,
    input logic [63:0] cfg_q,
    input logic [63:0] cmp_q,
    input logic [63:0] msg_q
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmp_q == '1 && msg_q == '0 && cfg_q[63:32] == ROUTE_CAP));

    p_cfg_hi_kept_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && (addr_i == 3'd0 || addr_i == 3'd1)) |=> (cfg_q[63:32] == $past(cfg_q[63:32])));

    p_trunc_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == 3'd0 && wdata_i[8]) |=> (cmp_q[63:32] == 32'h0));

    p_setval_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == 3'd2) |=> !cfg_q[6]);

    p_narrow_hi_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == 3'd3 && cfg_q[8]) |=> $stable(cmp_q[63:32]));

    p_msg_half_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == 3'd4) |=> (msg_q[63:32] == $past(msg_q[63:32])));

    p_match_gated_r11: assert property (@(posedge clk) disable iff (rst)
        match_o |-> $past(irq_en_o && glb_en_i));
endmodule

bind evt_cmp_channel evt_cmp_channel_chk #(.ROUTE_CAP(ROUTE_CAP)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .glb_en_i (glb_en_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .match_o  (match_o),
    .irq_en_o (irq_en_o),
    .cfg_q    (cfg_q),
    .cmp_q    (cmp_q),
    .msg_q    (msg_q)
);

// File: tb/evt_cmp_channel_tb_top.sv
`timescale 1ns/1ps
module evt_cmp_channel_tb_top;
    localparam logic [31:0] ROUTE = 32'h00F0_0C00;
    localparam logic [63:0] PARK  = 64'h0123_4567_0000_0ABC;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] cnt_i;
    logic        glb_en_i;
    logic        wr_en_i;
    logic [2:0]  addr_i;
    logic [31:0] wdata_i;
    logic [31:0] rdata_o;
    logic        match_o;
    logic        irq_en_o;
    logic        level_type_o;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    evt_cmp_channel #(.ROUTE_CAP(ROUTE)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .cnt_i        (cnt_i),
        .glb_en_i     (glb_en_i),
        .wr_en_i      (wr_en_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .rdata_o      (rdata_o),
        .match_o      (match_o),
        .irq_en_o     (irq_en_o),
        .level_type_o (level_type_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cnt_i   = PARK;
        wr_en_i = 1'b1;
        addr_i  = a;
        wdata_i = d;
        @(posedge clk);
        #1;
        wr_en_i = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        wr_en_i = 1'b0;
        addr_i  = a;
        #1;
        check(req, {32'h0, rdata_o}, {32'h0, exp});
    endtask

    task automatic step(input logic [63:0] c, output logic m);
        @(negedge clk);
        cnt_i = c;
        @(posedge clk);
        #1;
        m = match_o;
        @(negedge clk);
        cnt_i = PARK;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic m;
        logic [31:0] ecmp;
        rst = 1'b1; cnt_i = PARK; glb_en_i = 1'b1;
        wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state, R8 unused words
        rd_chk("R1 cfg lo", 3'd0, 32'h0000_0030);
        rd_chk("R1 cfg hi", 3'd1, ROUTE);
        rd_chk("R1 cmp lo", 3'd2, 32'hFFFF_FFFF);
        rd_chk("R1 cmp hi", 3'd3, 32'hFFFF_FFFF);
        rd_chk("R1 msg lo", 3'd4, 32'h0);
        rd_chk("R1 msg hi", 3'd5, 32'h0);
        rd_chk("R8 word6", 3'd6, 32'h0);
        rd_chk("R8 word7", 3'd7, 32'h0);
        check("R12 ien reset", {63'h0, irq_en_o}, 64'h0);

        // R2 high config read-only
        wr(3'd1, 32'hFFFF_FFFF);
        rd_chk("R2 cfg hi ignored", 3'd1, ROUTE);

        // R3 truncate on 32-bit mode, R6 high write ignored
        wr(3'd0, 32'h0000_0100);
        rd_chk("R2 cfg lo replaced", 3'd0, 32'h0000_0100);
        rd_chk("R3 cmp hi cleared", 3'd3, 32'h0);
        rd_chk("R3 cmp lo kept", 3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0000_0005);
        rd_chk("R6 hi write ignored", 3'd3, 32'h0);

        // R12 output bits
        wr(3'd0, 32'h0000_0006);
        check("R12 ien", {63'h0, irq_en_o}, 64'h1);
        check("R12 level", {63'h0, level_type_o}, 64'h1);

        // one-shot, wide
        wr(3'd0, 32'h0000_0004);
        wr(3'd2, 32'd20);
        wr(3'd3, 32'd0);
        rd_chk("R4 oneshot cmp lo", 3'd2, 32'd20);
        rd_chk("R4 oneshot cmp hi", 3'd3, 32'd0);
        for (int c = 0; c <= 40; c++) begin
            step(64'(c), m);
            check("R9 R11 oneshot match", {63'h0, m}, {63'h0, (c == 20)});
        end
        for (int c = 0; c <= 40; c++) begin
            step(64'h1_0000_0000 + 64'(c), m);
            check("R9 wide no match", {63'h0, m}, 64'h0);
        end
        // R11 gating
        glb_en_i = 1'b0;
        step(64'd20, m);
        check("R11 global off", {63'h0, m}, 64'h0);
        glb_en_i = 1'b1;
        wr(3'd0, 32'h0000_0000);
        step(64'd20, m);
        check("R11 channel off", {63'h0, m}, 64'h0);
        // narrow compare
        wr(3'd0, 32'h0000_0104);
        for (int c = 0; c <= 40; c++) begin
            step(64'h7_0000_0000 + 64'(c), m);
            check("R9 narrow match", {63'h0, m}, {63'h0, (c == 20)});
        end

        // periodic, wide
        wr(3'd0, 32'h0000_004C);
        wr(3'd3, 32'd0);
        rd_chk("R5 setval cleared", 3'd0, 32'h0000_000C);
        wr(3'd0, 32'h0000_004C);
        wr(3'd2, 32'd10);
        wr(3'd2, 32'd7);
        rd_chk("R4 periodic lo to period", 3'd2, 32'd10);
        wr(3'd3, 32'd0);
        rd_chk("R4 periodic hi to period", 3'd3, 32'd0);
        for (int c = 0; c <= 60; c++) begin
            step(64'(c), m);
            check("R10 periodic match", {63'h0, m},
                  {63'h0, (c >= 10 && ((c - 10) % 7) == 0)});
        end
        rd_chk("R10 cmp advanced", 3'd2, 32'd66);

        // periodic, 32-bit mode with wrap
        wr(3'd0, 32'h0000_014C);
        wr(3'd2, 32'hFFFF_FFFE);
        wr(3'd2, 32'd4);
        ecmp = 32'hFFFF_FFFE;
        for (int i = 0; i < 32; i++) begin
            logic [63:0] c;
            logic        e;
            c = 64'h1_FFFF_FFF0 + 64'(i);
            e = (c[31:0] == ecmp);
            step(c, m);
            check("R10 narrow wrap match", {63'h0, m}, {63'h0, e});
            if (e) ecmp = ecmp + 32'd4;
        end
        rd_chk("R10 narrow cmp lo", 3'd2, ecmp);
        rd_chk("R10 narrow cmp hi", 3'd3, 32'h0);

        // R7 message halves
        wr(3'd4, 32'hAAAA_5555);
        rd_chk("R7 msg lo", 3'd4, 32'hAAAA_5555);
        rd_chk("R7 msg hi kept", 3'd5, 32'h0);
        wr(3'd5, 32'h1234_5678);
        rd_chk("R7 msg hi", 3'd5, 32'h1234_5678);
        rd_chk("R7 msg lo kept", 3'd4, 32'hAAAA_5555);

        finish_run();
    end
endmodule